// File: doc/BRIEF.md
# Star Hub Address Sequencer

This block sits between the instruction-list fetch of a bus controller on a star network and the serializer that transmits its command words. It takes one 16-bit command word at a time through a valid/ready handshake. It drives the 5-bit terminal address onto a parallel side port so that an external hub can open the matching link. It then waits a fixed lead time before it starts the serializer. The hub address does not change until the response phase is reported as finished, either by a completed response or by a timeout.

Two configuration inputs control the block. One enables the parallel address output. When both inputs are set, the block runs in link addressing mode. In that mode the address still comes from the instruction-list word, but the word handed to the serializer carries zero in its address field. Both inputs are latched when a command is accepted, so changes during a command do not affect it.

Top module: `hub_addr_seq`

## Requirements
- R1: After reset, `hub_addr_vld` is 0, `hub_addr` is 0, `ser_start` is 0 and `cmd_ready` is 1.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. From the next cycle `cmd_ready` is 0 until the response phase ends. A `cmd_valid` presented while `cmd_ready` is 0 is ignored.
- R3: With `cfg_hub_en`=1 at acceptance, `hub_addr` equals bits 15:11 of the accepted word from the cycle after acceptance, and `hub_addr_vld` is 1.
- R4: With `cfg_hub_en`=0 at acceptance, `hub_addr` stays 0 and `hub_addr_vld` stays 0 for the whole command.
- R5: `ser_start` is a one-cycle pulse. It rises exactly `LEAD_CYC` cycles after the cycle in which the hub address first becomes visible (default 25). With hub output disabled, the same timing counts from the cycle after acceptance.
- R6: From acceptance until release, `hub_addr` and `hub_addr_vld` remain constant.
- R7: Link mode is selected when `cfg_hub_en`=1 and `cfg_link_mode`=1. In link mode, `ser_word` bits 15:11 are 00000 while `ser_start` is 1, and bits 10:0 equal the accepted word.
- R8: Outside link mode, including `cfg_link_mode`=1 with `cfg_hub_en`=0, `ser_word` equals the accepted word while `ser_start` is 1.
- R9: `resp_done` is ignored before `ser_start` has pulsed.
- R10: Configuration changes after acceptance do not alter the address, its valid flag or the serialized word of the command in progress.
- R11: When `resp_done` is 1 on an edge at or after the `ser_start` cycle, the next cycle shows `hub_addr_vld`=0, `hub_addr`=0 and `cmd_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_hub_en | input | 1 | Enables the parallel hub address output |
| cfg_link_mode | input | 1 | With cfg_hub_en, selects link addressing mode |
| cmd_valid | input | 1 | Command word offered |
| cmd_word | input | 16 | Command word from the instruction list |
| cmd_ready | output | 1 | Block idle and able to accept a command |
| resp_done | input | 1 | Response finished or timed out |
| hub_addr | output | 5 | Parallel hub address |
| hub_addr_vld | output | 1 | Hub address is being driven |
| ser_start | output | 1 | One-cycle start strobe to the serializer |
| ser_word | output | 16 | Word for the serializer, valid with ser_start |

## Verification
The bench checks the exact cycle of the serializer strobe against the lead time. A counter that is off by one would let transmission begin before the hub has switched, or would waste a cycle. It sends `resp_done` pulses during the lead window, which a design that listened too early would take as an early release. It also flips the configuration in the middle of a command, which an unlatched design would let corrupt the address or the word. Link mode is tested with all-ones and all-zeros addresses, and with the link bit set alone while the hub output is off. These show whether the field clear is gated by both bits.

// File: rtl/hub_seq_pkg.sv
package hub_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LEAD = 2'd1,
      ST_RESP = 2'd2
   } seq_state_t;

   typedef struct packed {
      logic hub_en;
      logic link;
   } seq_cfg_t;

endpackage

// File: rtl/hub_lead_timer.sv
module hub_lead_timer #(
   parameter int LEAD_CYC = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic fire
);
   localparam int CNT_W = (LEAD_CYC < 2) ? 1 : $clog2(LEAD_CYC);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   if (LEAD_CYC < 1) begin : g_bad_lead
      $error("LEAD_CYC must be at least 1");
   end

   assign fire = run_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (arm) begin
         cnt_q <= CNT_W'(LEAD_CYC - 1);
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   a_r5_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !arm) |=> !fire);
   a_r5_no_rearm_running: assert property (@(posedge clk) disable iff (!rst_n)
      arm |-> !run_q);

endmodule

// File: rtl/hub_word_shaper.sv
module hub_word_shaper #(
   parameter int WORD_W   = 16,
   parameter int ADDR_W   = 5,
   parameter int ADDR_LSB = 11
) (
   input  logic [WORD_W-1:0] word_in,
   input  logic              link,
   output logic [WORD_W-1:0] word_out,
   output logic [ADDR_W-1:0] addr_field
);
   localparam int ADDR_MSB = ADDR_LSB + ADDR_W - 1;

   if (ADDR_MSB >= WORD_W) begin : g_bad_field
      $error("address field does not fit inside the word");
   end

   assign addr_field = word_in[ADDR_MSB:ADDR_LSB];

   if (ADDR_MSB == WORD_W - 1 && ADDR_LSB == 0) begin : g_full
      assign word_out = link ? '0 : word_in;
   end else if (ADDR_MSB == WORD_W - 1) begin : g_top
      assign word_out = {link ? {ADDR_W{1'b0}} : addr_field, word_in[ADDR_LSB-1:0]};
   end else if (ADDR_LSB == 0) begin : g_bottom
      assign word_out = {word_in[WORD_W-1:ADDR_MSB+1], link ? {ADDR_W{1'b0}} : addr_field};
   end else begin : g_mid
      assign word_out = {word_in[WORD_W-1:ADDR_MSB+1],
                         link ? {ADDR_W{1'b0}} : addr_field,
                         word_in[ADDR_LSB-1:0]};
   end

endmodule

// File: rtl/hub_addr_reg.sv
module hub_addr_reg #(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              release_i,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr,
   output logic              vld
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
         vld  <= 1'b0;
      end else if (release_i) begin
         addr <= '0;
         vld  <= 1'b0;
      end else if (load) begin
         addr <= addr_in;
         vld  <= 1'b1;
      end
   end

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !release_i) |=> (vld && $stable(addr)));
   a_r4_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |-> (addr == '0));

endmodule

// File: rtl/hub_addr_seq.sv
module hub_addr_seq
   import hub_seq_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int ADDR_W   = 5,
   parameter int ADDR_LSB = 11,
   parameter int LEAD_CYC = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_hub_en,
   input  logic              cfg_link_mode,
   input  logic              cmd_valid,
   input  logic [WORD_W-1:0] cmd_word,
   output logic              cmd_ready,
   input  logic              resp_done,
   output logic [ADDR_W-1:0] hub_addr,
   output logic              hub_addr_vld,
   output logic              ser_start,
   output logic [WORD_W-1:0] ser_word
);
   seq_state_t        st_q;
   seq_cfg_t          cfg_q;
   seq_cfg_t          cfg_now;
   logic              accept;
   logic              release_c;
   logic              fire;
   logic [WORD_W-1:0] shaped;
   logic [ADDR_W-1:0] field;

   assign cfg_now.hub_en = cfg_hub_en;
   assign cfg_now.link   = cfg_hub_en & cfg_link_mode;

   assign cmd_ready = (st_q == ST_IDLE);
   assign accept    = cmd_valid && cmd_ready;
   assign release_c = (st_q == ST_RESP) && resp_done;

   hub_word_shaper #(
      .WORD_W  (WORD_W),
      .ADDR_W  (ADDR_W),
      .ADDR_LSB(ADDR_LSB)
   ) u_shaper (
      .word_in   (cmd_word),
      .link      (cfg_now.link),
      .word_out  (shaped),
      .addr_field(field)
   );

   hub_lead_timer #(.LEAD_CYC(LEAD_CYC)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .arm  (accept),
      .fire (fire)
   );

   hub_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept && cfg_now.hub_en),
      .release_i(release_c),
      .addr_in  (field),
      .addr     (hub_addr),
      .vld      (hub_addr_vld)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cfg_q     <= '0;
         ser_start <= 1'b0;
         ser_word  <= '0;
      end else begin
         ser_start <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (accept) begin
               st_q     <= ST_LEAD;
               cfg_q    <= cfg_now;
               ser_word <= shaped;
            end
            ST_LEAD: if (fire) begin
               st_q      <= ST_RESP;
               ser_start <= 1'b1;
            end
            ST_RESP: if (resp_done) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   a_r2_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !cmd_ready);
   a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !cfg_hub_en) |=> (!hub_addr_vld && hub_addr == '0));
   a_r7_link_field_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_start && cfg_q.link) |-> (ser_word[ADDR_LSB+ADDR_W-1:ADDR_LSB] == '0));
   a_r10_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_ready && !release_c) |=> $stable(ser_word));
   a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
      release_c |=> (cmd_ready && !hub_addr_vld));
   a_r9_start_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ser_start |-> !cmd_ready);

endmodule

// File: tb/hub_addr_seq_tb.sv
module hub_addr_seq_tb;
   localparam int LEAD = 25;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_hub_en = 1'b0;
   logic        cfg_link_mode = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] cmd_word = '0;
   logic        resp_done = 1'b0;
   logic        cmd_ready;
   logic [4:0]  hub_addr;
   logic        hub_addr_vld;
   logic        ser_start;
   logic [15:0] ser_word;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // behavioural reference state
   int          m_phase = 0;   // 0 idle, 1 busy
   int          m_age = 0;     // cycles since acceptance
   bit          m_en = 1'b0;
   bit          m_link = 1'b0;
   logic [15:0] m_word = '0;

   always #10 clk = ~clk;

   hub_addr_seq u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_hub_en(cfg_hub_en), .cfg_link_mode(cfg_link_mode),
      .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
      .resp_done(resp_done), .hub_addr(hub_addr), .hub_addr_vld(hub_addr_vld),
      .ser_start(ser_start), .ser_word(ser_word)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_age = 0;
      end else if (m_phase == 0) begin
         if (cmd_valid) begin
            m_phase = 1; m_age = 0;
            m_en = cfg_hub_en; m_link = cfg_hub_en && cfg_link_mode;
            m_word = cmd_word;
         end
      end else if (m_age >= LEAD && resp_done) begin
         m_phase = 0;
      end else begin
         m_age++;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic        e_vld;
         logic [15:0] e_word;
         e_vld = (m_phase == 1) && m_en;
         chk("R2 cmd_ready (R11 after release)", cmd_ready, m_phase == 0);
         chk("R3/R4/R6 hub_addr_vld", hub_addr_vld, e_vld);
         chk("R3/R4/R6/R10 hub_addr", hub_addr, e_vld ? m_word[15:11] : 5'd0);
         chk("R5/R9 ser_start", ser_start, (m_phase == 1) && (m_age == LEAD));
         if (ser_start) begin
            e_word = m_link ? {5'd0, m_word[10:0]} : m_word;
            chk("R7/R8 ser_word", ser_word, e_word);
         end
      end
   end

   task automatic run_cmd(input logic [15:0] w, input bit en, input bit lnk,
                          input bit early, input bit flip, input bit poke);
      @(negedge clk);
      cfg_hub_en = en; cfg_link_mode = lnk;
      cmd_valid = 1'b1; cmd_word = w;
      @(negedge clk);
      cmd_valid = 1'b0;
      if (flip) begin cfg_hub_en = ~en; cfg_link_mode = ~lnk; end   // R10
      for (int i = 0; i < 200 && !ser_start; i++) begin
         if (early && i == 4) resp_done = 1'b1;                      // R9
         else resp_done = 1'b0;
         if (poke && i == 6) begin cmd_valid = 1'b1; cmd_word = ~w; end // R2
         else cmd_valid = 1'b0;
         @(negedge clk);
      end
      resp_done = 1'b0; cmd_valid = 1'b0;
      repeat (3) @(negedge clk);
      resp_done = 1'b1;                                              // R11
      @(negedge clk);
      resp_done = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ready", cmd_ready, 1);
      chk("R1 vld", hub_addr_vld, 0);
      chk("R1 addr", hub_addr, 0);
      chk("R1 start", ser_start, 0);
      run_cmd(16'hA5C3, 1, 0, 0, 0, 0);   // R3 R8
      run_cmd(16'hFFFF, 1, 1, 0, 0, 0);   // R7 all-ones address
      run_cmd(16'h07FF, 1, 1, 0, 0, 0);   // R7 zero address
      run_cmd(16'h9234, 0, 0, 0, 0, 0);   // R4
      run_cmd(16'hC0DE, 0, 1, 0, 0, 0);   // R8 link bit alone
      run_cmd(16'h5A5A, 1, 0, 1, 0, 0);   // R9 early resp_done
      run_cmd(16'h3B17, 1, 1, 0, 1, 0);   // R10 config flip
      run_cmd(16'h8421, 1, 0, 0, 0, 1);   // R2 valid while busy
      run_cmd(16'h1357, 1, 1, 1, 1, 1);   // combined
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule